// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

An 8-bit general-purpose I/O port attached to a small register bus. Each pin has an output latch bit and a direction bit. A single pull-up control is shared by all pins. Selected pins can hand their output over to a peripheral signal. Pin levels pass through a synchroniser before software reads them. Reading the port also refreshes a snapshot of the pin levels. Whenever the synchronised levels differ from that snapshot, a sticky change flag is raised. The flag, gated by its enable bit, drives an interrupt request.

The block has two reset inputs. The system reset puts the direction, control, override and flag state back to defaults. The power-on reset does the same and also clears the output latch. A system reset on its own leaves the latch untouched.

Top module: `gpio_change_port`

## Requirements
- R1: After either reset the direction register reads 0xFF (address 1), so every pin is an input and `pin_oe_o` is 0x00.
- R2: The output latch (address 0, write) is cleared to 0x00 by a power-on reset only. A system reset alone keeps its value, and the value can be seen on `pin_o`.
- R3: Direction bit 1 means input and 0 means output, so `pin_oe_o` is the inverse of the direction register. Writing 0xCF drives only bits 5:4.
- R4: `pin_o` carries the latch value on every bit without an active override. A read of address 0 returns `pin_i` after the two-flop synchroniser, whatever the direction setting.
- R5: Override register (address 4): a set bit routes `periph_out_i` of that pin to `pin_o`, taking precedence over the latch. Only bits in the OVR_MASK parameter (default 0x0C) can be written. Other bits read 0 and have no effect.
- R6: Control register (address 2) bit 0 is an active-low pull-up enable that resets to 0. `pull_up_o` equals the direction register when that bit is 0 and is 0x00 when it is 1.
- R7: The change flag sets on any cycle where the synchronised pins differ from the snapshot. Each read of address 0 reloads the snapshot with the synchronised pins.
- R8: Flag register (address 3) bit 0 reads the change flag. Writing 1 to bit 0 clears it, but a change in the same cycle wins. The flag resets to 0.
- R9: `irq_o` is the change flag ANDed with control bit 1 (the interrupt enable), and that enable resets to 0.
- R10: Reads of unmapped addresses (5 to 7) return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables, 1 = drive |
| pull_up_o | output | 8 | Per-pad weak pull-up enables |
| periph_out_i | input | 8 | Peripheral output signals for override |
| pin_sync_o | output | 8 | Synchronised pin levels for peripheral inputs |
| irq_o | output | 1 | Change interrupt request |

## Verification
On every cycle, the assertions check the following:
- the latch stays stable unless its address is written;
- a direction write lands the next cycle;
- a port read reloads the snapshot;
- a snapshot mismatch raises the flag;
- the flag holds until it is cleared.

The bench scenarios cover what needs stimulus sequences:
- the split between the two resets;
- the synchroniser latency seen at the read port;
- override masking and precedence;
- the pull-up gating;
- the clear-versus-set priority of the flag;
- the handling of unmapped addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_CTRL = 3'd2,
    REG_FLAG = 3'd3,
    REG_OVR  = 3'd4
  } reg_addr_e;

  localparam int CTRL_PU_N_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int FLAG_BIT      = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int          WIDTH    = 8,
  parameter logic [WIDTH-1:0] OVR_MASK = 8'h0C
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] ovr_o,
  output logic             pu_n_o,
  output logic             ie_o
);
  logic [WIDTH-1:0] latch_q, dir_q, ovr_q;
  logic             pu_n_q, ie_q;

  // latch survives system reset; only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                          latch_q <= '0;
    else if (wr_i && addr_i == REG_DATA) latch_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      ovr_q  <= '0;
      pu_n_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        REG_DIR:  dir_q <= wdata_i;
        REG_OVR:  ovr_q <= wdata_i & OVR_MASK;
        REG_CTRL: begin
          pu_n_q <= wdata_i[CTRL_PU_N_BIT];
          ie_q   <= wdata_i[CTRL_IE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign ovr_o   = ovr_q;
  assign pu_n_o  = pu_n_q;
  assign ie_o    = ie_q;

  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(wr_i && addr_i == REG_DATA) |=> $stable(latch_q));

  // R3
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DIR) |=> dir_q == $past(wdata_i));
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic             flag_o
);
  logic [WIDTH-1:0] snap_q;
  logic             flag_q;
  logic             mismatch;

  assign mismatch = |(sync_i ^ snap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (rd_i) snap_q <= sync_i;
      // a new change wins over a clear in the same cycle
      if (mismatch)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R7
  snap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> snap_q == $past(sync_i));

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i != snap_q) |=> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/gpio_change_port.sv
module gpio_change_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OVR_MASK    = 8'h0C
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pull_up_o,
  input  logic [WIDTH-1:0] periph_out_i,
  output logic [WIDTH-1:0] pin_sync_o,
  output logic             irq_o
);
  logic             rst_any_n;
  logic             wr, rd_data, clr_flag;
  logic [WIDTH-1:0] latch, dir, ovr, sync;
  logic             pu_n, ie, flag;

  assign rst_any_n = rst_ni & por_ni;
  assign wr        = sel_i & we_i;
  assign rd_data   = sel_i & ~we_i & (addr_i == REG_DATA);
  assign clr_flag  = wr & (addr_i == REG_FLAG) & wdata_i[FLAG_BIT];

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_any_n),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .OVR_MASK(OVR_MASK)) u_regs (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .rst_ni (rst_any_n),
    .wr_i   (wr),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .latch_o(latch),
    .dir_o  (dir),
    .ovr_o  (ovr),
    .pu_n_o (pu_n),
    .ie_o   (ie)
  );

  gpio_change #(.WIDTH(WIDTH)) u_change (
    .clk_i (clk_i),
    .rst_ni(rst_any_n),
    .rd_i  (rd_data),
    .clr_i (clr_flag),
    .sync_i(sync),
    .flag_o(flag)
  );

  // per-pin pad drive: override takes precedence over the latch
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pin_o[i]     = ovr[i] ? periph_out_i[i] : latch[i];
    assign pin_oe_o[i]  = ~dir[i];
    assign pull_up_o[i] = ~pu_n & dir[i];
  end

  assign pin_sync_o = sync;
  assign irq_o      = flag & ie;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DATA: rdata_o = sync;
      REG_DIR:  rdata_o = dir;
      REG_OVR:  rdata_o = ovr;
      REG_CTRL: begin
        rdata_o[CTRL_PU_N_BIT] = pu_n;
        rdata_o[CTRL_IE_BIT]   = ie;
      end
      REG_FLAG: rdata_o[FLAG_BIT] = flag;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: tb/gpio_change_port_test.sv
module gpio_change_port_test;
  logic       clk_i = 1'b0;
  logic       por_ni = 1'b0, rst_ni = 1'b0;
  logic       sel_i = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, pin_i = '0, periph_out_i = '0;
  logic [7:0] rdata_o, pin_o, pin_oe_o, pull_up_o, pin_sync_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  localparam logic [7:0] MASK = 8'h0C;

  always #10 clk_i = ~clk_i;

  gpio_change_port uut (.*);

  function automatic logic [7:0] exp_pin(logic [7:0] lat, logic [7:0] ovr, logic [7:0] per);
    return (ovr & per) | (~ovr & lat);
  endfunction

  function automatic logic [7:0] exp_pu(logic pu_n, logic [7:0] dir);
    return pu_n ? 8'h00 : dir;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2 d = rdata_o;
    @(negedge clk_i);
    sel_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, lat, dir, ovr, per, pins;
    logic       pu_n;
    int unsigned seed;
    seed = $urandom(32'd2024);

    idle(3);
    por_ni = 1'b1; rst_ni = 1'b1;
    idle(4);
    // R1 reset state
    rd(3'd1, v);   chk("R1 dir reset", v, 8'hFF);
    chk("R1 oe reset", pin_oe_o, 8'h00);
    // R2 latch cleared on power-on
    chk("R2 latch after POR", pin_o, 8'h00);
    // R6 pull-ups on by default for inputs
    chk("R6 pull-up reset", pull_up_o, 8'hFF);
    // R8 / R9 flag and irq idle
    rd(3'd3, v);   chk("R8 flag reset", v, 8'h00);
    chk("R9 irq reset", {7'b0, irq_o}, 8'h00);

    // R3 0xCF direction pattern
    wr(3'd1, 8'hCF);
    chk("R3 oe for 0xCF", pin_oe_o, 8'h30);
    chk("R6 pull-up follows dir", pull_up_o, 8'hCF);

    // R2 system reset keeps latch, restores dir
    wr(3'd0, 8'hA5);
    chk("R4 latch on pin_o", pin_o, 8'hA5);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    idle(1);
    chk("R2 latch kept over system reset", pin_o, 8'hA5);
    chk("R1 oe after system reset", pin_oe_o, 8'h00);
    @(negedge clk_i); por_ni = 1'b0;
    @(negedge clk_i); por_ni = 1'b1;
    idle(1);
    chk("R2 latch cleared by POR", pin_o, 8'h00);

    // R5 override precedence and masking
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    periph_out_i = 8'hFF;
    wr(3'd4, 8'hFF);
    rd(3'd4, v);   chk("R5 override readback masked", v, MASK);
    chk("R5 override drives peripheral", pin_o, MASK);
    wr(3'd4, 8'h00);

    // R6 pull-up disable
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'h01);
    chk("R6 pull-up disabled", pull_up_o, 8'h00);
    wr(3'd2, 8'h00);
    chk("R6 pull-up enabled", pull_up_o, 8'hF0);

    // R10 unmapped addresses
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd5, v);   chk("R10 unmapped read", v, 8'h00);
    rd(3'd1, v);   chk("R10 dir untouched", v, 8'hF0);
    rd(3'd2, v);   chk("R10 ctrl untouched", v, 8'h00);
    rd(3'd4, v);   chk("R10 ovr untouched", v, 8'h00);

    // R7 / R8 / R9 change detection
    pin_i = 8'h00;
    idle(3);
    rd(3'd0, v);
    wr(3'd3, 8'h01);
    idle(2);
    rd(3'd3, v);   chk("R7 no change no flag", v, 8'h00);
    pin_i = 8'h10;
    idle(4);
    rd(3'd3, v);   chk("R7 flag on change", v, 8'h01);
    chk("R9 irq masked", {7'b0, irq_o}, 8'h00);
    wr(3'd2, 8'h02);
    chk("R9 irq enabled", {7'b0, irq_o}, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, v);   chk("R8 set wins over clear", v, 8'h01);
    rd(3'd0, v);   chk("R4 port read sync level", v, 8'h10);
    wr(3'd3, 8'h00);
    rd(3'd3, v);   chk("R8 write 0 leaves flag", v, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, v);   chk("R8 clear after reload", v, 8'h00);
    chk("R9 irq low after clear", {7'b0, irq_o}, 8'h00);
    pin_i = 8'h00;
    idle(4);
    chk("R7 flag on return change", {7'b0, irq_o}, 8'h01);
    rd(3'd0, v);
    wr(3'd3, 8'h01);
    wr(3'd2, 8'h00);

    // R4 synchroniser latency: two flops
    @(negedge clk_i); pin_i = 8'h5A;
    @(negedge clk_i); chk("R4 sync stage 1", pin_sync_o, 8'h00);
    @(negedge clk_i); chk("R4 sync stage 2", pin_sync_o, 8'h5A);

    // random mix: R3 R4 R5 R6
    for (int k = 0; k < 40; k++) begin
      lat  = 8'($urandom);
      dir  = 8'($urandom);
      ovr  = 8'($urandom);
      per  = 8'($urandom);
      pins = 8'($urandom);
      pu_n = 1'($urandom);
      periph_out_i = per;
      pin_i = pins;
      wr(3'd0, lat);
      wr(3'd1, dir);
      wr(3'd4, ovr);
      wr(3'd2, {7'b0, pu_n});
      idle(2);
      chk("R3 random oe", pin_oe_o, ~dir);
      chk("R5 random pin_o", pin_o, exp_pin(lat, ovr & MASK, per));
      chk("R6 random pull-up", pull_up_o, exp_pu(pu_n, dir));
      rd(3'd0, v);   chk("R4 random port read", v, pins);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule